// File: doc/BRIEF.md
# Protected Watchdog Timer with Unlock Refresh

This block is a supervision timer built on a down-counter (15 bits by default). Software keeps it alive by writing a two-step key into its kick register. If the counter is allowed to run out, the block raises either a one-cycle interrupt pulse or a one-cycle reset request. In normal mode the count source is the CPU clock tick passed through a prescaler. The prescaler divides by 16 or 128, or by 2 while the sub clock is selected. In normal mode the count freezes while the system sleeps, waits or yields the bus.

A protected mode can be entered from a reset-time strap or from a software write. It cannot be left except by reset. In protected mode each low-speed oscillator tick moves the counter directly, no halt condition applies, and running out always requests a reset. A second strap selects between two ways of starting: counting begins straight after reset, or it waits for the first write to the start register.

Two small state machines hold the control. The key machine has the states KEY_IDLE and KEY_ARMED. Its transitions are: arm, taken when the kick register is written with 00h; fire, taken from KEY_ARMED when the kick register is written with FFh, which returns to KEY_IDLE; and abandon, taken on any other write while armed. The run machine has the states RUN_HALT and RUN_COUNT. Its reset state comes from the start strap. Its only transition is start, from RUN_HALT to RUN_COUNT on a write to the start register.

Top module: `wdog_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, the counter is all ones, ctrl_rdata reads 1Fh (counter top bits 11111, both control bits 0), and wdt_irq and wdt_rst_req are 0.
- R2: With strap_autostart=1 at reset, counting begins right after reset. With it 0, the counter holds until any write to address 1, and counting begins on the cycle after that write.
- R3: A write of 00h to address 0 followed by a write of FFh to address 0 reloads the counter to all ones and clears the prescaler at that clock edge. Any other write between them abandons the sequence. A refresh landing on the same edge as an underflow wins, and no event is raised.
- R4: In normal mode, the counter steps once per 16 qualifying cpu_tick strobes when address 2 bit 7 is 0, and once per 128 when that bit is 1.
- R5: While sub_clk_sel is 1, the normal-mode prescaler divides by 2 whatever address 2 bit 7 holds.
- R6: In normal mode, cpu_tick strobes seen while in_stop, in_wait or in_bus_hold is 1 are ignored.
- R7: In normal mode, a step taken at zero reloads all ones. On the next cycle it gives a one-cycle wdt_irq pulse if address 2 bit 6 is 0, or a one-cycle wdt_rst_req pulse if that bit is 1.
- R8: In protected mode, each slow_tick steps the counter and cpu_tick is ignored. The halt inputs have no effect, and an underflow always gives a wdt_rst_req pulse.
- R9: Protected mode is on after reset when strap_guard=1. A write to address 3 with bit 7 set also turns it on. A later write of 0 does not clear it.
- R10: ctrl_rdata is {address 2 bit 7, address 2 bit 6, 0, counter top five bits}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; straps sampled while low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 kick, 1 start, 2 control, 3 protection |
| wr_data | input | 8 | Write data |
| strap_autostart | input | 1 | 1: count from reset; 0: wait for start write |
| strap_guard | input | 1 | 1: protected mode from reset |
| cpu_tick | input | 1 | CPU clock enable strobe |
| slow_tick | input | 1 | Low-speed oscillator enable strobe |
| sub_clk_sel | input | 1 | Sub clock selected, forces divide by 2 |
| in_stop | input | 1 | System in stop mode |
| in_wait | input | 1 | System in wait mode |
| in_bus_hold | input | 1 | Bus held by another master |
| wdt_irq | output | 1 | Underflow interrupt pulse |
| wdt_rst_req | output | 1 | Underflow reset request pulse |
| ctrl_rdata | output | 8 | Control read view with counter top bits |

## Verification
A refresh fire write and an underflow can land on the same clock edge. The bench provokes this from its own reference model. It writes the arming 00h early, then waits until the model shows the counter at zero with the prescaler one tick from stepping, and issues the FFh write in that exact cycle. The reset-action bit is set during this test, so a design that let the underflow through would raise wdt_rst_req. The bench judges the collision by requiring no event pulse on the following cycle and a read-back of all-ones top bits.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 8;
    localparam int RD_BITS = 5;

    localparam logic [ADDR_W-1:0] A_KICK  = 2'd0;
    localparam logic [ADDR_W-1:0] A_START = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
    localparam logic [ADDR_W-1:0] A_GUARD = 2'd3;

    localparam logic [DATA_W-1:0] KEY_ARM  = 8'h00;
    localparam logic [DATA_W-1:0] KEY_FIRE = 8'hFF;

    localparam int CTRL_DIV_BIT = 7;
    localparam int CTRL_ACT_BIT = 6;
    localparam int GUARD_EN_BIT = 7;

    typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_t;
    typedef enum logic {RUN_HALT, RUN_COUNT} run_state_t;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              kick_ok
);
    key_state_t st_q, st_d;
    logic       arm_w, fire_w;

    assign arm_w  = wr_en && (wr_addr == A_KICK) && (wr_data == KEY_ARM);
    assign fire_w = wr_en && (wr_addr == A_KICK) && (wr_data == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KEY_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KEY_IDLE:  if (arm_w) st_d = KEY_ARMED;             // arm
            KEY_ARMED: if (wr_en && !arm_w) st_d = KEY_IDLE;     // fire or abandon
        endcase
    end

    always_comb kick_ok = (st_q == KEY_ARMED) && fire_w;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV_LO  = 16,
    parameter int DIV_HI  = 128,
    parameter int DIV_SUB = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic clear,
    input  logic div_hi,
    input  logic sub_sel,
    output logic step
);
    localparam int PW = $clog2(DIV_HI);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim_m1;

    always_comb begin
        if (sub_sel)     lim_m1 = PW'(DIV_SUB - 1);
        else if (div_hi) lim_m1 = PW'(DIV_HI - 1);
        else             lim_m1 = PW'(DIV_LO - 1);
    end

    // >= keeps the divider from running away after a ratio change
    assign step = en && tick && (pre_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) pre_q <= '0;
        else if (en && tick) pre_q <= step ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_start,
    input  logic             start_req,
    input  logic             step,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    run_state_t       run_q, run_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= auto_start ? RUN_COUNT : RUN_HALT;
        else        run_q <= run_d;
    end

    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_HALT:  if (start_req) run_d = RUN_COUNT;         // start
            RUN_COUNT: run_d = RUN_COUNT;
        endcase
    end

    assign running   = (run_q == RUN_COUNT);
    assign underflow = running && step && !reload && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || reload || underflow) cnt_q <= CNT_MAX;
        else if (running && step)          cnt_q <= cnt_q - 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int DIV_LO  = 16,
    parameter int DIV_HI  = 128,
    parameter int DIV_SUB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              strap_autostart,
    input  logic              strap_guard,
    input  logic              cpu_tick,
    input  logic              slow_tick,
    input  logic              sub_clk_sel,
    input  logic              in_stop,
    input  logic              in_wait,
    input  logic              in_bus_hold,
    output logic              wdt_irq,
    output logic              wdt_rst_req,
    output logic [DATA_W-1:0] ctrl_rdata
);
    logic             div_q, act_q, guard_q;
    logic             irq_q, rst_q;
    logic             kick_ok, pre_step, step, halted;
    logic             running, underflow;
    logic [CNT_W-1:0] cnt_w;
    logic             ctrl_we, start_we, guard_we;

    assign ctrl_we  = wr_en && (wr_addr == A_CTRL);
    assign start_we = wr_en && (wr_addr == A_START);
    assign guard_we = wr_en && (wr_addr == A_GUARD) && wr_data[GUARD_EN_BIT];
    assign halted   = in_stop || in_wait || in_bus_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= 1'b0;
            act_q   <= 1'b0;
            guard_q <= strap_guard;
        end else begin
            if (ctrl_we) begin
                div_q <= wr_data[CTRL_DIV_BIT];
                act_q <= wr_data[CTRL_ACT_BIT];
            end
            if (guard_we) guard_q <= 1'b1;
        end
    end

    wdog_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .kick_ok (kick_ok)
    );

    wdog_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .DIV_SUB(DIV_SUB)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (running && !guard_q),
        .tick    (cpu_tick && !halted),
        .clear   (kick_ok || underflow),
        .div_hi  (div_q),
        .sub_sel (sub_clk_sel),
        .step    (pre_step)
    );

    assign step = guard_q ? slow_tick : pre_step;

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_start (strap_autostart),
        .start_req  (start_we),
        .step       (step),
        .reload     (kick_ok),
        .cnt        (cnt_w),
        .running    (running),
        .underflow  (underflow)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            irq_q <= underflow && !guard_q && !act_q;
            rst_q <= underflow && (guard_q || act_q);
        end
    end

    assign wdt_irq     = irq_q;
    assign wdt_rst_req = rst_q;
    assign ctrl_rdata  = {div_q, act_q, 1'b0, cnt_w[CNT_W-1 -: RD_BITS]};
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdt_irq,
    input logic             wdt_rst_req,
    input logic             in_stop,
    input logic             in_wait,
    input logic             in_bus_hold,
    input logic             guard_q,
    input logic             running,
    input logic             kick_ok,
    input logic             underflow,
    input logic [CNT_W-1:0] cnt_w
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq |=> !wdt_irq); // R7
    AST_NO_DUAL_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_irq && wdt_rst_req)); // R7
    AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (cnt_w == '1)); // R7
    AST_REFRESH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kick_ok |=> (cnt_w == '1) && !wdt_irq && !wdt_rst_req); // R3
    AST_GUARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        guard_q |=> guard_q); // R9
    AST_GUARD_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        guard_q |=> !wdt_irq); // R8
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_q && (in_stop || in_wait || in_bus_hold) && !kick_ok) |=> $stable(cnt_w)); // R6
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !kick_ok) |=> $stable(cnt_w)); // R2
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdt_irq     (wdt_irq),
    .wdt_rst_req (wdt_rst_req),
    .in_stop     (in_stop),
    .in_wait     (in_wait),
    .in_bus_hold (in_bus_hold),
    .guard_q     (guard_q),
    .running     (running),
    .kick_ok     (kick_ok),
    .underflow   (underflow),
    .cnt_w       (cnt_w)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 10;
    localparam int MAXV       = (1 << TB_CNT_W) - 1;
    localparam int WD_LIMIT   = 150000;

    logic       clk, rst_n, wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       strap_autostart, strap_guard, cpu_tick, slow_tick, sub_clk_sel;
    logic       in_stop, in_wait, in_bus_hold;
    logic       wdt_irq, wdt_rst_req;
    logic [7:0] ctrl_rdata;

    int    nchk = 0, nfail = 0, cyc = 0;
    int    irq_seen = 0, rst_seen = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt, m_pre, m_lim;
    bit m_armed, m_div, m_act, m_guard, m_run, m_irq, m_rst, m_fire, m_stp, m_uf;

    wdog_guard #(.CNT_W(TB_CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .strap_autostart(strap_autostart), .strap_guard(strap_guard),
        .cpu_tick(cpu_tick), .slow_tick(slow_tick), .sub_clk_sel(sub_clk_sel),
        .in_stop(in_stop), .in_wait(in_wait), .in_bus_hold(in_bus_hold),
        .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req), .ctrl_rdata(ctrl_rdata)
    );

    initial clk = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model_rd();
        logic [4:0] top;
        top = 5'(m_cnt >> (TB_CNT_W - 5));
        return {m_div, m_act, 1'b0, top};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = MAXV; m_pre = 0; m_armed = 0; m_div = 0; m_act = 0;
            m_guard = strap_guard; m_run = strap_autostart; m_irq = 0; m_rst = 0;
        end else begin
            m_fire = wr_en && wr_addr == 2'd0 && wr_data == 8'hFF && m_armed;
            m_lim  = sub_clk_sel ? 2 : (m_div ? 128 : 16);
            m_stp  = 0;
            m_uf   = 0;
            if (m_guard) m_stp = slow_tick;
            else if (m_run && cpu_tick && !(in_stop || in_wait || in_bus_hold)) begin
                if (m_pre >= m_lim - 1) begin m_pre = 0; m_stp = 1; end
                else m_pre++;
            end
            if (m_fire) begin
                m_cnt = MAXV; m_pre = 0;
            end else if (m_run && m_stp) begin
                if (m_cnt == 0) begin m_cnt = MAXV; m_pre = 0; m_uf = 1; end
                else m_cnt--;
            end
            m_irq = m_uf && !m_guard && !m_act;
            m_rst = m_uf && (m_guard || m_act);
            if (wr_en) begin
                m_armed = (wr_addr == 2'd0 && wr_data == 8'h00);
                if (wr_addr == 2'd1) m_run = 1;
                if (wr_addr == 2'd2) begin m_div = wr_data[7]; m_act = wr_data[6]; end
                if (wr_addr == 2'd3 && wr_data[7]) m_guard = 1;
            end
        end
    end

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, {wdt_irq, wdt_rst_req, ctrl_rdata}, {m_irq, m_rst, model_rd()});
            if (wdt_irq) irq_seen++;
            if (wdt_rst_req) rst_seen++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            report();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_reset(input bit auto_s, input bit guard_s);
        strap_autostart = auto_s; strap_guard = guard_s;
        rst_n = 0;
        idle(3);
        rst_n = 1;
    endtask

    logic [7:0] saved;

    initial begin
        wr_en = 0; wr_addr = 0; wr_data = 0; cpu_tick = 0; slow_tick = 0;
        sub_clk_sel = 0; in_stop = 0; in_wait = 0; in_bus_hold = 0; rst_n = 0;
        @(negedge clk);
        cur_req = "R1";
        do_reset(0, 0);
        chk("R1", ctrl_rdata, 8'h1F);
        chk("R1", {wdt_irq, wdt_rst_req}, 0);

        cur_req = "R2";
        cpu_tick = 1;
        idle(200);
        chk("R2", ctrl_rdata, 8'h1F);
        wr(2'd1, 8'h00);
        idle(600);
        cur_req = "R4";
        chk("R4", ctrl_rdata, model_rd());
        chk("R2", ctrl_rdata[4:0] < 5'h1F, 1);

        cur_req = "R3";
        wr(2'd0, 8'h00);
        wr(2'd0, 8'hFF);
        chk("R3", ctrl_rdata, 8'h1F);
        idle(600);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFF);
        chk("R3", ctrl_rdata[4:0] == 5'h1F, 0);

        cur_req = "R4";
        wr(2'd2, 8'h80);
        idle(3000);
        chk("R4", ctrl_rdata, model_rd());
        chk("R10", ctrl_rdata[7:5], 3'b100);

        cur_req = "R5";
        sub_clk_sel = 1;
        idle(300);
        chk("R5", ctrl_rdata, model_rd());

        cur_req = "R6";
        saved = ctrl_rdata;
        in_stop = 1; idle(150); in_stop = 0;
        in_wait = 1; idle(150); in_wait = 0;
        in_bus_hold = 1; idle(150); in_bus_hold = 0;
        chk("R6", ctrl_rdata, saved);

        cur_req = "R7";
        wr(2'd2, 8'h00);
        irq_seen = 0; rst_seen = 0;
        idle(2100);
        chk("R7", irq_seen, 1);
        chk("R7", rst_seen, 0);
        wr(2'd2, 8'h40);
        irq_seen = 0; rst_seen = 0;
        idle(2100);
        chk("R7", rst_seen, 1);
        chk("R7", irq_seen, 0);
        chk("R10", ctrl_rdata[7:5], 3'b010);

        // refresh and underflow on the same edge
        cur_req = "R3";
        wr(2'd0, 8'h00);
        while (!(m_cnt == 0 && m_pre == 1)) @(negedge clk);
        rst_seen = 0;
        wr(2'd0, 8'hFF);
        chk("R3", wdt_rst_req, 0);
        chk("R3", ctrl_rdata[4:0], 5'h1F);
        idle(2);
        chk("R3", rst_seen, 0);

        cur_req = "R8";
        wr(2'd3, 8'h80);
        wr(2'd3, 8'h00);
        saved = ctrl_rdata;
        idle(300);
        chk("R8", ctrl_rdata, saved);
        wr(2'd2, 8'h00);
        in_stop = 1; slow_tick = 1;
        irq_seen = 0; rst_seen = 0;
        idle(1100);
        chk("R8", rst_seen, 1);
        chk("R9", irq_seen, 0);
        in_stop = 0;

        cur_req = "R9";
        do_reset(1, 1);
        irq_seen = 0; rst_seen = 0;
        idle(1100);
        chk("R9", rst_seen, 1);
        chk("R2", irq_seen, 0);

        done = 1;
        report();
    end
endmodule